// File: doc/BRIEF.md
# MCU power mode clock controller

This block governs the reduced-power behaviour of a small 8-bit microcontroller. The core writes a power control register that has two mode bits, one for idle and one for power-down. From these bits the block drives four gate enables:

- the core clock enable;
- the USB clock enable;
- the peripheral clock enable;
- the oscillator enable.

The gates themselves, the oscillator, the core and the peripherals lie outside the block. They are modelled as enables and single-cycle pulses. Each enable is registered on the falling edge of the oscillator clock, so a downstream gate cell only ever sees it change while the clock is low.

The block also forms the core clock by dividing the oscillator clock. A 3-bit prescaler code selects the ratio, and the result is presented as `core_tick`, a one-oscillator-cycle pulse per divided period. The watchdog is clocked from the same `core_tick`, so it runs only while the core runs. All other peripherals use the undivided clock.

Wake-up depends on the mode. In idle, the hardware clears the mode bit on any enabled interrupt or any supervisor reset. In power-down, interrupts are ignored and only an external, low-voltage or debug reset brings the part back. After any accepted supervisor reset the block holds the core in reset for three divided-clock (machine) cycles. All pins are plain control and status; there is no data stream and so no back-pressure.

Top module: `pcm_clk_ctrl`

## Requirements
- R1: After `rst_n` is released the block is in run mode: `core_clk_en`, `usb_clk_en`, `periph_clk_en` and `osc_en` are 1, and `mode_idle`, `mode_pd` and `cpu_rst` are 0. The prescaler starts with code 0.
- R2: A run-mode write (`pcon_wr`=1) with `pcon_idle`=1 and `pcon_pd`=0 sets `mode_idle`. By the following falling edge `core_clk_en` is 0, while `usb_clk_en`, `periph_clk_en` and `osc_en` stay 1.
- R3: A run-mode write with `pcon_pd`=1 sets `mode_pd`. By the following falling edge all four enables are 0.
- R4: A write with both bits set enters power-down: `mode_pd`=1 and `mode_idle`=0.
- R5: In idle, `irq_req`=1 clears `mode_idle` and restores `core_clk_en` without asserting `cpu_rst`.
- R6: In idle, `sup_rst_ext`, `sup_rst_lvd` or `sup_rst_dbg` clears `mode_idle` and raises `cpu_rst`. `cpu_rst` then stays 1 for exactly three `core_tick` pulses.
- R7: In power-down, `irq_req`, `sup_rst_wdt` and register writes have no effect. An external, low-voltage or debug reset ends power-down, re-enables all four clocks and holds `cpu_rst` for three `core_tick` pulses.
- R8: `sup_rst_wdt` raises `cpu_rst` in run mode but is ignored in idle.
- R9: Prescaler codes 0..7 give `core_tick` periods of 2, 4, 8, 16, 32, 128, 512 and 2048 oscillator cycles.
- R10: A new prescaler code is taken only at a divided-period boundary. The period in progress completes at the old ratio.
- R11: `core_tick` (and with it the watchdog clock) is never asserted in idle or power-down.
- R12: A write with neither bit set has no effect, and writes are ignored while `cpu_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pcon_wr | input | 1 | Power control register write strobe |
| pcon_idle | input | 1 | Idle bit value being written |
| pcon_pd | input | 1 | Power-down bit value being written |
| presc_code | input | 3 | Core clock divide code |
| irq_req | input | 1 | Any enabled interrupt request |
| sup_rst_ext | input | 1 | Supervisor reset from the external reset pin |
| sup_rst_lvd | input | 1 | Supervisor reset from the low-voltage detector |
| sup_rst_dbg | input | 1 | Supervisor reset from a debug command |
| sup_rst_wdt | input | 1 | Supervisor reset from the watchdog |
| core_clk_en | output | 1 | Core clock gate enable |
| usb_clk_en | output | 1 | USB clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_tick | output | 1 | Divided core clock pulse, also the watchdog clock |
| cpu_rst | output | 1 | Core reset hold after a supervisor reset |
| mode_idle | output | 1 | Idle bit readback |
| mode_pd | output | 1 | Power-down bit readback |

## Verification
The divider is swept through all eight codes, measuring the gap between consecutive `core_tick` pulses. A code change made just after a pulse shows whether the new ratio is applied early or only at the boundary. Each mode is then hit with every wake source in turn: interrupt, watchdog reset and the three external reset kinds. The resulting mode bits, gate enables and `cpu_rst` pulse count show which sources each mode honours. Writes with both bits set, with neither bit set, and during the restart hold separate the priority rule from the write-ignore rules.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_state_e;

  localparam int PRESC_W     = 3;
  localparam int DIV_CNT_W   = 11;
  localparam int RESTART_CYC = 3;

  localparam int GATE_CORE   = 0;
  localparam int GATE_USB    = 1;
  localparam int GATE_PERIPH = 2;
  localparam int GATE_OSC    = 3;
  localparam int NUM_GATES   = 4;

  // log2 of the divide ratio for each prescaler code
  function automatic logic [3:0] div_shift(input logic [PRESC_W-1:0] code);
    case (code)
      3'd0:    div_shift = 4'd1;
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd3;
      3'd3:    div_shift = 4'd4;
      3'd4:    div_shift = 4'd5;
      3'd5:    div_shift = 4'd7;
      3'd6:    div_shift = 4'd9;
      default: div_shift = 4'd11;
    endcase
  endfunction
endpackage

// File: rtl/pcm_mode_ctrl.sv
module pcm_mode_ctrl
  import pcm_pkg::*;
#(
  parameter int RST_HOLD = RESTART_CYC
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic      wr_idle,
  input  logic      wr_pd,
  input  logic      irq,
  input  logic      rst_ext,
  input  logic      rst_lvd,
  input  logic      rst_dbg,
  input  logic      rst_wdt,
  input  logic      div_tick,
  output pm_state_e state,
  output logic      hold_rst
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [HOLD_W-1:0] hold_cnt;
  logic              wake_hard;
  logic              wake_any;

  // watchdog reset only counts when the core clock runs
  assign wake_hard = rst_ext | rst_lvd | rst_dbg;
  assign wake_any  = wake_hard | (rst_wdt & (state == PM_RUN));
  assign hold_rst  = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PM_RUN;
      hold_cnt <= '0;
    end else if (wake_any) begin
      state    <= PM_RUN;
      hold_cnt <= HOLD_W'(RST_HOLD);
    end else begin
      if (hold_rst && div_tick) hold_cnt <= hold_cnt - 1'b1;
      case (state)
        PM_RUN: begin
          if (wr && !hold_rst) begin
            if (wr_pd)        state <= PM_DOWN;
            else if (wr_idle) state <= PM_IDLE;
          end
        end
        PM_IDLE: if (irq) state <= PM_RUN;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcm_prescaler.sv
module pcm_prescaler
  import pcm_pkg::*;
#(
  parameter int CNT_W = DIV_CNT_W,
  parameter int CW    = PRESC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          tick
);
  logic [CNT_W-1:0] cnt;
  logic [CW-1:0]    cur_code;
  logic [CNT_W-1:0] lim;

  assign lim = CNT_W'((32'd1 << div_shift(cur_code)) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_code <= '0;
      tick     <= 1'b0;
    end else if (!run) begin
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt      <= '0;
      cur_code <= code;
      tick     <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_gate_bank.sv
module pcm_gate_bank
  import pcm_pkg::*;
#(
  parameter int NG = NUM_GATES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pm_state_e     state,
  output logic [NG-1:0] gate
);
  logic [NG-1:0] want;

  always_comb begin
    for (int i = 0; i < NG; i++) want[i] = (state != PM_DOWN);
    want[GATE_CORE] = (state == PM_RUN);
  end

  for (genvar g = 0; g < NG; g++) begin : g_gate
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate[g] <= 1'b1;
      else        gate[g] <= want[g];
    end
  end
endmodule

// File: rtl/pcm_clk_ctrl.sv
module pcm_clk_ctrl
  import pcm_pkg::*;
(
  input  logic               clk_osc,
  input  logic               rst_n,
  input  logic               pcon_wr,
  input  logic               pcon_idle,
  input  logic               pcon_pd,
  input  logic [PRESC_W-1:0] presc_code,
  input  logic               irq_req,
  input  logic               sup_rst_ext,
  input  logic               sup_rst_lvd,
  input  logic               sup_rst_dbg,
  input  logic               sup_rst_wdt,
  output logic               core_clk_en,
  output logic               usb_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               core_tick,
  output logic               cpu_rst,
  output logic               mode_idle,
  output logic               mode_pd
);
  pm_state_e            state;
  logic                 div_tick;
  logic [NUM_GATES-1:0] gate;

  pcm_mode_ctrl #(.RST_HOLD(RESTART_CYC)) u_mode (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .wr       (pcon_wr),
    .wr_idle  (pcon_idle),
    .wr_pd    (pcon_pd),
    .irq      (irq_req),
    .rst_ext  (sup_rst_ext),
    .rst_lvd  (sup_rst_lvd),
    .rst_dbg  (sup_rst_dbg),
    .rst_wdt  (sup_rst_wdt),
    .div_tick (div_tick),
    .state    (state),
    .hold_rst (cpu_rst)
  );

  pcm_gate_bank #(.NG(NUM_GATES)) u_gates (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .state (state),
    .gate  (gate)
  );

  pcm_prescaler #(.CNT_W(DIV_CNT_W), .CW(PRESC_W)) u_presc (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .run   (gate[GATE_OSC]),
    .code  (presc_code),
    .tick  (div_tick)
  );

  assign core_clk_en   = gate[GATE_CORE];
  assign usb_clk_en    = gate[GATE_USB];
  assign periph_clk_en = gate[GATE_PERIPH];
  assign osc_en        = gate[GATE_OSC];
  assign core_tick     = div_tick & gate[GATE_CORE];
  assign mode_idle     = (state == PM_IDLE);
  assign mode_pd       = (state == PM_DOWN);
endmodule

// File: rtl/pcm_clk_ctrl_chk.sv
module pcm_clk_ctrl_chk (
  input logic clk_osc,
  input logic rst_n,
  input logic irq_req,
  input logic sup_rst_ext,
  input logic sup_rst_lvd,
  input logic sup_rst_dbg,
  input logic sup_rst_wdt,
  input logic core_clk_en,
  input logic usb_clk_en,
  input logic periph_clk_en,
  input logic osc_en,
  input logic core_tick,
  input logic cpu_rst,
  input logic mode_idle,
  input logic mode_pd
);
  logic hard_rst;
  assign hard_rst = sup_rst_ext | sup_rst_lvd | sup_rst_dbg;

  a_r2_idle_gates: assert property (@(posedge clk_osc) disable iff (!rst_n)
    mode_idle |-> (!core_clk_en && usb_clk_en && periph_clk_en && osc_en));

  a_r3_pd_gates: assert property (@(posedge clk_osc) disable iff (!rst_n)
    mode_pd |-> (!core_clk_en && !usb_clk_en && !periph_clk_en && !osc_en));

  a_r5_irq_wake: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_idle && irq_req) |=> !mode_idle);

  a_r6_hard_rst_hold: assert property (@(posedge clk_osc) disable iff (!rst_n)
    hard_rst |=> (cpu_rst && !mode_idle && !mode_pd));

  a_r7_pd_irq_ignored: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_pd && !hard_rst) |=> (mode_pd && !cpu_rst));

  a_r8_idle_wdt_ignored: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_idle && sup_rst_wdt && !hard_rst && !irq_req) |=> (mode_idle && !cpu_rst));

  a_r11_no_tick_asleep: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (mode_idle || mode_pd) |-> !core_tick);
endmodule

bind pcm_clk_ctrl pcm_clk_ctrl_chk u_chk (.*);

// File: tb/test_pcm_clk_ctrl.sv
module test_pcm_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCODES = 8;
  localparam int unsigned EXP_DIV [NCODES] = '{2, 4, 8, 16, 32, 128, 512, 2048};

  logic clk_osc = 1'b0;
  logic rst_n = 1'b0;
  logic pcon_wr = 1'b0, pcon_idle = 1'b0, pcon_pd = 1'b0;
  logic [2:0] presc_code = 3'd0;
  logic irq_req = 1'b0;
  logic sup_rst_ext = 1'b0, sup_rst_lvd = 1'b0, sup_rst_dbg = 1'b0, sup_rst_wdt = 1'b0;
  logic core_clk_en, usb_clk_en, periph_clk_en, osc_en, core_tick, cpu_rst, mode_idle, mode_pd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

  pcm_clk_ctrl i_pcm_clk_ctrl (
    .clk_osc(clk_osc), .rst_n(rst_n), .pcon_wr(pcon_wr), .pcon_idle(pcon_idle),
    .pcon_pd(pcon_pd), .presc_code(presc_code), .irq_req(irq_req),
    .sup_rst_ext(sup_rst_ext), .sup_rst_lvd(sup_rst_lvd), .sup_rst_dbg(sup_rst_dbg),
    .sup_rst_wdt(sup_rst_wdt), .core_clk_en(core_clk_en), .usb_clk_en(usb_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .core_tick(core_tick),
    .cpu_rst(cpu_rst), .mode_idle(mode_idle), .mode_pd(mode_pd)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic mid();
    @(negedge clk_osc); #1;
  endtask

  task automatic pcon_write(input logic idl, input logic pd);
    @(posedge clk_osc); #1;
    pcon_wr = 1'b1; pcon_idle = idl; pcon_pd = pd;
    @(posedge clk_osc); #1;
    pcon_wr = 1'b0; pcon_idle = 1'b0; pcon_pd = 1'b0;
    mid();
  endtask

  // src: 0 ext, 1 lvd, 2 dbg, 3 wdt, 4 irq
  task automatic pulse(input int src);
    @(posedge clk_osc); #1;
    case (src)
      0: sup_rst_ext = 1'b1;
      1: sup_rst_lvd = 1'b1;
      2: sup_rst_dbg = 1'b1;
      3: sup_rst_wdt = 1'b1;
      default: irq_req = 1'b1;
    endcase
    @(posedge clk_osc); #1;
    {sup_rst_ext, sup_rst_lvd, sup_rst_dbg, sup_rst_wdt, irq_req} = '0;
    mid();
  endtask

  task automatic wait_tick();
    int g = 0;
    while (!core_tick && g < 5000) begin mid(); g++; end
  endtask

  // call while core_tick is high; returns cycles to the next pulse
  task automatic period(output int n);
    n = 0;
    do begin mid(); n++; end while (!core_tick && n < 5000);
  endtask

  task automatic count_hold(output int n);
    int g = 0;
    n = 0;
    while (cpu_rst && g < 10000) begin
      if (core_tick) n++;
      mid(); g++;
    end
  endtask

  task automatic count_ticks(input int cyc, output int n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin mid(); if (core_tick) n++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p, n;
    repeat (3) @(posedge clk_osc);
    #1 rst_n = 1'b1;
    mid();
    // R1 reset state
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 usb/periph/osc", {usb_clk_en, periph_clk_en, osc_en}, 3'b111);
    chk("R1 mode bits", {mode_idle, mode_pd}, 0);
    chk("R1 cpu_rst", cpu_rst, 0);

    // R9 ratio table walked by one loop
    for (int i = 0; i < NCODES; i++) begin
      presc_code = 3'(i);
      wait_tick(); period(p); period(p); period(p);
      chk($sformatf("R9 code %0d period", i), p, int'(EXP_DIV[i]));
    end

    // R10 change takes effect at boundary
    presc_code = 3'd2;
    wait_tick(); period(p); period(p);
    presc_code = 3'd4;
    period(p);
    chk("R10 old ratio completes", p, 8);
    period(p);
    chk("R10 new ratio after boundary", p, 32);

    presc_code = 3'd0;
    wait_tick(); period(p); period(p);

    // R2 idle entry
    pcon_write(1'b1, 1'b0);
    chk("R2 mode_idle", mode_idle, 1);
    chk("R2 core_clk_en off", core_clk_en, 0);
    chk("R2 usb/periph/osc on", {usb_clk_en, periph_clk_en, osc_en}, 3'b111);
    count_ticks(40, n);
    chk("R11 no tick in idle", n, 0);

    // R8 watchdog ignored in idle
    pulse(3);
    chk("R8 idle kept on wdt", mode_idle, 1);
    chk("R8 no cpu_rst in idle", cpu_rst, 0);

    // R5 interrupt wake
    pulse(4);
    chk("R5 idle cleared", mode_idle, 0);
    chk("R5 core_clk_en back", core_clk_en, 1);
    chk("R5 no cpu_rst", cpu_rst, 0);

    // R6 supervisor reset from idle
    pcon_write(1'b1, 1'b0);
    pulse(0);
    chk("R6 idle cleared by ext reset", mode_idle, 0);
    chk("R6 cpu_rst raised", cpu_rst, 1);
    count_hold(n);
    chk("R6 hold machine cycles", n, 3);

    // R8 watchdog in run, R12 write during hold
    pulse(3);
    chk("R8 wdt reset in run", cpu_rst, 1);
    pcon_write(1'b1, 1'b0);
    chk("R12 write ignored during hold", mode_idle, 0);
    count_hold(n);
    pcon_write(1'b0, 1'b0);
    chk("R12 empty write no effect", {mode_idle, mode_pd, core_clk_en}, 3'b001);

    // R3 power-down
    pcon_write(1'b0, 1'b1);
    chk("R3 mode_pd", mode_pd, 1);
    chk("R3 all enables off", {core_clk_en, usb_clk_en, periph_clk_en, osc_en}, 0);
    pulse(4);
    chk("R7 irq ignored in pd", {mode_pd, core_clk_en}, 2'b10);
    pulse(3);
    chk("R7 wdt ignored in pd", {mode_pd, cpu_rst}, 2'b10);
    pcon_write(1'b1, 1'b0);
    chk("R7 write ignored in pd", {mode_pd, mode_idle}, 2'b10);
    count_ticks(40, n);
    chk("R11 no tick in pd", n, 0);
    pulse(1);
    chk("R7 lvd exits pd", {mode_pd, core_clk_en, usb_clk_en, periph_clk_en, osc_en}, 5'b01111);
    count_hold(n);
    chk("R7 hold after pd exit", n, 3);

    // R4 both bits set
    pcon_write(1'b1, 1'b1);
    chk("R4 pd wins", {mode_pd, mode_idle}, 2'b10);
    pulse(2);
    chk("R7 dbg exits pd", {mode_pd, cpu_rst}, 2'b01);
    count_hold(n);

    // R1 async reset from power-down
    pcon_write(1'b0, 1'b1);
    #2 rst_n = 1'b0;
    #3;
    chk("R1 async reset enables", {core_clk_en, usb_clk_en, periph_clk_en, osc_en}, 4'b1111);
    chk("R1 async reset mode", {mode_idle, mode_pd, cpu_rst}, 0);
    @(posedge clk_osc); #1 rst_n = 1'b1;
    mid();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule